// File: doc/BRIEF.md
# Serial Delay-Code Programming Register

This block is the programming side of an 8-bit programmable timing element. A host loads a delay code over three wires: an enable, a serial clock and a serial data line. While the enable is high, each rising edge of the serial clock moves one data bit into an internal shift register, most significant bit first. When the enable drops, the shifted value is copied into a holding register. That register is the active delay code. It is decoded into a one-hot bus with one line per delay tap: the zero-delay path plus 255 unit cells. The analog delay cells are not part of this block.

The most significant bit of the shift register is always driven on a serial output. Several devices can be daisy-chained by wiring each serial output to the next device's data input and sharing the enable and serial clock. The same output lets a host read the stored code back. A read shifts the register, so it is non-destructive only if the host feeds every bit it reads back into the data input.

The three serial pins are sampled by the block's system clock. The host must drive them synchronously to that clock and hold each serial-clock level for at least one system cycle. Edges are found by comparing each sample with the previous one.

Top module: `dly_code_serial`

## Requirements
- R1: A synchronous active-low reset clears the shift register and the holding register to zero. After reset the code output is 0, the serial output is 0 and only select line 0 is high.
- R2: When a rising serial-clock edge is seen while the enable is high, the shift register moves up one place and takes the data bit into bit 0. Eight such edges load a byte sent most significant bit first.
- R3: Serial-clock edges seen while the enable is low change neither the shift register nor the holding register.
- R4: When the enable falls from high to low, the holding register takes the shift-register value. The new code appears on the code output one system cycle after the falling level is sampled.
- R5: The holding register keeps its value while bits are shifted in with the enable high. A rising enable changes nothing.
- R6: The serial output always shows the current shift-register MSB. After each shift it presents the new MSB before the next serial-clock edge.
- R7: When two blocks are chained (serial output to the next data input, enable and serial clock shared), 16 shifted bits followed by a falling enable load the first byte into the far device and the second byte into the near device.
- R8: Reading eight bits from the serial output while feeding each bit back into the data input returns the stored code MSB first and leaves it intact after commit. Reading while driving zeros returns the code and clears it after commit.
- R9: The select bus has exactly one line high, and that line's index equals the code output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial enable: shifting while high, commit on falling level |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising level change |
| ser_d | input | 1 | Serial data input |
| ser_q | output | 1 | Serial output, current shift-register MSB |
| code_o | output | CODE_W | Active delay code from the holding register |
| tap_sel_o | output | 2**CODE_W | One-hot tap select, line n high for code n |

## Verification
The bench builds two instances with the default CODE_W of 8, and the second takes the first one's serial output as its data input. At this width every one of the 256 codes can be written and its select line checked exhaustively. The chained pair brings 16-bit cascade loading within reach. It also covers reads with and without feedback, and serial clocks while the enable is low, all observed at the code, select and serial-output ports.

// File: rtl/dly_code_pkg.sv
// Package: shared width default and the serial event record passed
// from the pin sampler to the storage stages.
package dly_code_pkg;

    localparam int DEFAULT_CODE_W = 8;

    // Per-cycle serial events, all qualified in the system clock domain.
    typedef struct packed {
        logic shift;   // rising serial-clock level change with enable high
        logic commit;  // enable was high last sample, low now
    } ser_evt_t;

endpackage

// File: rtl/dly_code_edge.sv
// Module: dly_code_edge
// Samples the serial clock and enable with the system clock and turns
// level changes into single-cycle shift and commit events.
// Assumes: pins are already synchronous to clk; every serial-clock level
// lasts at least one clk cycle.
module dly_code_edge
    import dly_code_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ser_en_i,
    input  logic     ser_clk_i,
    output ser_evt_t evt_o
);

    logic clk_prev_q;
    logic en_prev_q;

    // Purpose: remember the previous sample of serial clock and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            en_prev_q  <= 1'b0;
        end else begin
            clk_prev_q <= ser_clk_i;
            en_prev_q  <= ser_en_i;
        end
    end

    // Purpose: derive this cycle's events from the current and previous samples.
    always_comb begin
        evt_o.shift  = ser_clk_i && !clk_prev_q && ser_en_i;
        evt_o.commit = en_prev_q && !ser_en_i;
    end

    // R3: no shift event is raised while the enable is low.
    p_no_shift_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_i |-> !evt_o.shift);

endmodule

// File: rtl/dly_code_shift.sv
// Module: dly_code_shift
// Serial-in shift register, MSB first. The MSB is the serial output.
// Assumes: the shift event is a one-cycle pulse from dly_code_edge.
module dly_code_shift #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              data_i,
    output logic [CODE_W-1:0] sr_o,
    output logic              msb_o
);

    logic [CODE_W-1:0] sr_q;

    // Purpose: move up one place and take the data bit into bit 0 on a shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[CODE_W-2:0], data_i};
        end
    end

    assign sr_o  = sr_q;
    assign msb_o = sr_q[CODE_W-1];

    // R2: a shift takes the old lower bits plus the data bit.
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> sr_q == {$past(sr_q[CODE_W-2:0]), $past(data_i)});

    // R3: without a shift event the register keeps its value.
    p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(sr_q));

endmodule

// File: rtl/dly_code_hold.sv
// Module: dly_code_hold
// Holding register for the active delay code. It loads the shift
// register on a commit event and holds its value otherwise.
// Assumes: commit is a one-cycle pulse.
module dly_code_hold #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] sr_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] code_q;

    // Purpose: copy the shift register into the active code on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (commit_i) begin
            code_q <= sr_i;
        end
    end

    assign code_o = code_q;

    // R4: after a commit the code equals the shift register seen at commit.
    p_commit_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> code_q == $past(sr_i));

    // R5: without a commit the active code does not move.
    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(code_q));

endmodule

// File: rtl/dly_code_decode.sv
// Module: dly_code_decode
// Turns a binary code into 2**CODE_W one-hot tap select lines.
// Purely combinational; one comparator per line.
module dly_code_decode #(
    parameter int CODE_W = 8,
    localparam int TAPS  = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [TAPS-1:0]   sel_o
);

    // Purpose: raise line n exactly when the code equals n.
    for (genvar n = 0; n < TAPS; n++) begin : g_tap
        assign sel_o[n] = (code_i == CODE_W'(n));
    end

endmodule

// File: rtl/dly_code_serial.sv
// Module: dly_code_serial (top)
// Three-wire programming port for a delay code: it samples the pins,
// shifts data in MSB first, commits on a falling enable and decodes the
// active code into one-hot tap selects. The shift-register MSB drives
// ser_q for chaining and read-back.
// Assumes: serial pins are synchronous to clk and each level of ser_clk
// lasts at least one clk cycle.
module dly_code_serial
    import dly_code_pkg::*;
#(
    parameter int  CODE_W = DEFAULT_CODE_W,
    localparam int TAPS   = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_d,
    output logic              ser_q,
    output logic [CODE_W-1:0] code_o,
    output logic [TAPS-1:0]   tap_sel_o
);

    ser_evt_t          evt;
    logic [CODE_W-1:0] sr;

    dly_code_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_en_i  (ser_en),
        .ser_clk_i (ser_clk),
        .evt_o     (evt)
    );

    dly_code_shift #(.CODE_W(CODE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (evt.shift),
        .data_i  (ser_d),
        .sr_o    (sr),
        .msb_o   (ser_q)
    );

    dly_code_hold #(.CODE_W(CODE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (evt.commit),
        .sr_i     (sr),
        .code_o   (code_o)
    );

    dly_code_decode #(.CODE_W(CODE_W)) u_dec (
        .code_i (code_o),
        .sel_o  (tap_sel_o)
    );

    // R1: reset leaves a zero code and a low serial output.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0) && !ser_q);

    // R6: after a shift the serial output shows the bit that moved into the MSB.
    p_q_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt.shift |=> ser_q == $past(sr[CODE_W-2]));

    // R9: exactly one select line is high.
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1);

    // R9: the high line is the one indexed by the code.
    p_sel_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel_o[code_o] == 1'b1);

endmodule

// File: tb/tb_dly_code_serial.sv
module tb_dly_code_serial;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int TAPS       = 1 << W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ser_en = 1'b0;
    logic            ser_clk = 1'b0;
    logic            ser_d = 1'b0;
    logic            ser_q, ser_q2;
    logic [W-1:0]    code, code2;
    logic [TAPS-1:0] sel, sel2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_code_serial #(.CODE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_d(ser_d), .ser_q(ser_q), .code_o(code), .tap_sel_o(sel)
    );

    // Second device in a chain: its data input is the first one's output.
    dly_code_serial #(.CODE_W(W)) dut2 (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_d(ser_q), .ser_q(ser_q2), .code_o(code2), .tap_sel_o(sel2)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One serial bit: data set with clock low, then a high level, then low.
    task automatic send_bit(input logic b);
        tick(); ser_d = b; ser_clk = 1'b0;
        tick(); ser_clk = 1'b1;
        tick(); ser_clk = 1'b0;
    endtask

    task automatic send_byte(input logic [W-1:0] v);
        for (int i = W-1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic write_code(input logic [W-1:0] v);
        tick(); ser_en = 1'b1;
        send_byte(v);
        tick(); ser_en = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 code", int'(code), 0);
        chk("R1 q", int'(ser_q), 0);
        chk("R1 sel", sel[0] && $countones(sel) == 1, 1);
    endtask

    task automatic t_patterns();
        logic [W-1:0] pats [6] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h01, 8'h80};
        foreach (pats[k]) begin
            write_code(pats[k]);
            chk("R2 R4 code", int'(code), int'(pats[k]));
            chk("R9 sel", sel[pats[k]], 1);
        end
    endtask

    task automatic t_sweep();
        for (int c = 0; c < TAPS; c++) begin
            write_code(W'(c));
            chk("R9 onehot", $countones(sel), 1);
            chk("R9 index", sel[c], 1);
        end
    endtask

    task automatic t_hold_and_q();
        write_code(8'h5A);
        tick(); ser_en = 1'b1;
        tick();
        chk("R5 rise", int'(code), 8'h5A);
        chk("R6 q start", int'(ser_q), 0);
        // Shift ones: register 5A -> B5 -> 6B -> D7 -> AF
        send_bit(1'b1); chk("R6 q1", int'(ser_q), 1);
        send_bit(1'b1); chk("R6 q2", int'(ser_q), 0);
        send_bit(1'b1); chk("R6 q3", int'(ser_q), 1);
        send_bit(1'b1); chk("R6 q4", int'(ser_q), 1);
        chk("R5 hold", int'(code), 8'h5A);
        tick(); ser_en = 1'b0;
        tick();
        chk("R4 commit", int'(code), 8'hAF);
    endtask

    task automatic t_idle_clocks();
        write_code(8'h96);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        chk("R3 code", int'(code), 8'h96);
        chk("R3 q", int'(ser_q), 1);
        tick(); ser_en = 1'b1;
        tick(); ser_en = 1'b0;
        tick();
        chk("R3 sr kept", int'(code), 8'h96);
    endtask

    task automatic t_readback();
        logic [W-1:0] got;
        write_code(8'hC3);
        tick(); ser_en = 1'b1;
        for (int i = W-1; i >= 0; i--) begin
            tick();
            got[i] = ser_q;
            send_bit(ser_q);
        end
        tick(); ser_en = 1'b0;
        tick();
        chk("R8 read value", int'(got), 8'hC3);
        chk("R8 kept", int'(code), 8'hC3);
        tick(); ser_en = 1'b1;
        for (int i = W-1; i >= 0; i--) begin
            tick();
            got[i] = ser_q;
            send_bit(1'b0);
        end
        tick(); ser_en = 1'b0;
        tick();
        chk("R8 destructive read", int'(got), 8'hC3);
        chk("R8 destroyed", int'(code), 0);
    endtask

    task automatic t_cascade();
        tick(); ser_en = 1'b1;
        send_byte(8'h12);
        send_byte(8'hE7);
        tick(); ser_en = 1'b0;
        tick();
        chk("R7 near", int'(code), 8'hE7);
        chk("R7 far", int'(code2), 8'h12);
        chk("R7 far sel", sel2[8'h12], 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_patterns();
        t_hold_and_q();
        t_idle_clocks();
        t_readback();
        t_cascade();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule